// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Entry

This block is the state machine that steps a shared multicycle datapath through each instruction. The datapath has one memory, one ALU, and internal holding registers for the instruction, the memory data, the two operands and the ALU result. Every instruction spends one cycle on fetch and one on decode. After that, the instruction class decides how many more cycles follow and which datapath resources each cycle uses.

The sequencer reads three things: the opcode held in the instruction register, a flag from the ALU decoder that says whether the function field of a register-format instruction is recognised, and the ALU's overflow and zero outputs. Each cycle it drives the datapath enables and multiplexer selects. The controls are registered by state, except that the PC load also depends on `alu_zero` in the branch state.

It detects two exceptions: an undefined instruction and arithmetic overflow. For either one it spends a single cycle doing four things. It has the ALU form PC minus 4 for the exception PC register, writes a cause code, loads the PC with the fixed handler address, and then returns to fetch.

Top module: `mc_control`

## Requirements
- R1: An active-low asynchronous reset puts the sequencer in the fetch state. Releasing reset at any point, including in the middle of an instruction, restarts with a fetch cycle.
- R2: Fetch cycle drives exactly these controls and holds every other output low:
  - `mem_read` = 1, `ir_write` = 1, `pc_load` = 1
  - `alu_src_b` = 01 (constant 4), `alu_src_a` = 0 (PC), `alu_op` = 00 (add), `pc_source` = 00 (ALU result)
- R3: Decode cycle, which follows every fetch, drives `alu_src_b` = 11 (shifted sign-extended immediate), `alu_src_a` = 0 and `alu_op` = 00, with every other output low.
- R4: A register-format instruction (opcode 0) with a recognised function field and no overflow takes 4 cycles.
  - Execute: `alu_src_a` = 1, `alu_src_b` = 00 (B), `alu_op` = 10 (function field).
  - Write-back: `reg_write` = 1, `reg_dst` = 1 (rd), `mem_to_reg` = 0.
- R5: A store (opcode 43) takes 4 cycles.
  - Address: `alu_src_a` = 1, `alu_src_b` = 10 (sign-extended immediate), `alu_op` = 00.
  - Memory write: `mem_write` = 1, `iord` = 1.
- R6: A load (opcode 35) takes 5 cycles.
  - The same address cycle as a store.
  - Memory read: `mem_read` = 1, `iord` = 1.
  - Write-back: `reg_write` = 1, `mem_to_reg` = 1, `reg_dst` = 0 (rt).
- R7: A branch-if-equal (opcode 4) takes 3 cycles. Its last cycle drives `alu_src_a` = 1, `alu_src_b` = 00, `alu_op` = 01 (subtract) and `pc_source` = 01 (ALU result register). In that cycle `pc_load` equals `alu_zero`.
- R8: A jump (opcode 2) takes 3 cycles. Its last cycle drives `pc_load` = 1 and `pc_source` = 10 (jump target).
- R9: Either of these conditions sends decode to an undefined-instruction cycle, so the instruction takes 3 cycles:
  - an opcode outside {0, 2, 4, 35, 43};
  - opcode 0 with `funct_known` = 0.
  The undefined-instruction cycle drives:
  - `cause_write` = 1, `cause_code` = 0, `epc_write` = 1
  - `alu_src_a` = 0, `alu_src_b` = 01, `alu_op` = 01 (PC minus 4)
  - `pc_load` = 1, `pc_source` = 11 (handler address 0x80000180)
- R10: `alu_overflow` high during the execute cycle of a register-format instruction leads to an overflow cycle instead of write-back. The overflow cycle drives the same controls as in R9 but with `cause_code` = 1. The instruction takes 4 cycles and never asserts `reg_write`.
- R11: `mem_write` is never high in the same cycle as `mem_read` or `reg_write`, and no memory or register-file write happens in any exception cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| funct_known | input | 1 | Function field of a register-format instruction is recognised |
| alu_overflow | input | 1 | ALU signed overflow for the current operation |
| alu_zero | input | 1 | ALU result is zero |
| pc_load | output | 1 | PC register load enable |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU result register |
| mem_read | output | 1 | Memory read |
| mem_write | output | 1 | Memory write |
| ir_write | output | 1 | Instruction register load |
| mem_to_reg | output | 1 | Register write data: 0 ALU result register, 1 memory data register |
| reg_dst | output | 1 | Destination register: 0 rt, 1 rd |
| reg_write | output | 1 | Register file write enable |
| alu_src_a | output | 1 | ALU A input: 0 PC, 1 operand A |
| alu_src_b | output | 2 | ALU B input: 00 B, 01 constant 4, 10 immediate, 11 immediate shifted by 2 |
| alu_op | output | 2 | 00 add, 01 subtract, 10 by function field |
| pc_source | output | 2 | Next PC: 00 ALU, 01 ALU result register, 10 jump target, 11 handler |
| cause_write | output | 1 | Cause register load |
| cause_code | output | 1 | Cause value: 0 undefined instruction, 1 overflow |
| epc_write | output | 1 | Exception PC register load (takes ALU output) |

## Verification
The properties assume three things about the inputs.
- The opcode and `funct_known` stay constant from decode until the instruction's last cycle. In the datapath this holds because the instruction register loads only during fetch.
- `alu_overflow` carries meaning only in the execute cycle.
- `alu_zero` carries meaning only in the branch cycle.

The stimulus follows these rules by setting all four inputs once, before each instruction's fetch, and holding them until the next fetch. It sweeps every one of the 64 opcodes against every combination of the three flag inputs, so overflow and zero are also driven in cycles where they must have no effect.

// File: rtl/mc_control.sv
module mc_control #(
  parameter logic [5:0] OP_RTYPE = 6'd0,
  parameter logic [5:0] OP_JUMP  = 6'd2,
  parameter logic [5:0] OP_BEQ   = 6'd4,
  parameter logic [5:0] OP_LOAD  = 6'd35,
  parameter logic [5:0] OP_STORE = 6'd43
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [5:0] opcode,
  input  logic       funct_known,
  input  logic       alu_overflow,
  input  logic       alu_zero,
  output logic       pc_load,
  output logic       iord,
  output logic       mem_read,
  output logic       mem_write,
  output logic       ir_write,
  output logic       mem_to_reg,
  output logic       reg_dst,
  output logic       reg_write,
  output logic       alu_src_a,
  output logic [1:0] alu_src_b,
  output logic [1:0] alu_op,
  output logic [1:0] pc_source,
  output logic       cause_write,
  output logic       cause_code,
  output logic       epc_write
);
  typedef enum logic [3:0] {
    FETCH, DECODE, ADDR, MRD, LDWB, MWR, EXEC, RWB, BRANCH, JUMP, UNDEF, OVF
  } state_t;

  state_t st, nxt;

  wire known_op = (opcode == OP_RTYPE) || (opcode == OP_JUMP) || (opcode == OP_BEQ)
               || (opcode == OP_LOAD) || (opcode == OP_STORE);
  wire illegal  = !known_op || (opcode == OP_RTYPE && !funct_known);
  wire exc      = (st == UNDEF) || (st == OVF);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= FETCH;
    else        st <= nxt;

  always_comb begin
    nxt = FETCH;
    case (st)
      FETCH:  nxt = DECODE;
      DECODE: begin
        if (illegal)                  nxt = UNDEF;
        else if (opcode == OP_RTYPE)  nxt = EXEC;
        else if (opcode == OP_BEQ)    nxt = BRANCH;
        else if (opcode == OP_JUMP)   nxt = JUMP;
        else                          nxt = ADDR;
      end
      ADDR:   nxt = (opcode == OP_LOAD) ? MRD : MWR;
      MRD:    nxt = LDWB;
      EXEC:   nxt = alu_overflow ? OVF : RWB;
      default: nxt = FETCH;
    endcase
  end

  assign pc_load     = (st == FETCH) || (st == JUMP) || exc || (st == BRANCH && alu_zero);
  assign iord        = (st == MRD) || (st == MWR);
  assign mem_read    = (st == FETCH) || (st == MRD);
  assign mem_write   = (st == MWR);
  assign ir_write    = (st == FETCH);
  assign mem_to_reg  = (st == LDWB);
  assign reg_dst     = (st == RWB);
  assign reg_write   = (st == RWB) || (st == LDWB);
  assign alu_src_a   = (st == ADDR) || (st == EXEC) || (st == BRANCH);
  assign alu_src_b   = (st == DECODE) ? 2'b11 :
                       (st == ADDR)   ? 2'b10 :
                       (st == FETCH || exc) ? 2'b01 : 2'b00;
  assign alu_op      = (st == EXEC) ? 2'b10 :
                       (st == BRANCH || exc) ? 2'b01 : 2'b00;
  assign pc_source   = exc ? 2'b11 :
                       (st == JUMP)   ? 2'b10 :
                       (st == BRANCH) ? 2'b01 : 2'b00;
  assign cause_write = exc;
  assign cause_code  = (st == OVF);
  assign epc_write   = exc;
endmodule

module mc_control_props (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode,
  input logic       funct_known,
  input logic       alu_overflow,
  input logic       alu_zero,
  input logic       pc_load,
  input logic       mem_read,
  input logic       mem_write,
  input logic       ir_write,
  input logic       reg_write,
  input logic       reg_dst,
  input logic       alu_src_a,
  input logic [1:0] alu_src_b,
  input logic [1:0] alu_op,
  input logic [1:0] pc_source,
  input logic       cause_write,
  input logic       cause_code,
  input logic       epc_write
);
  wire is_decode = (alu_src_b == 2'b11);
  wire is_exec   = (alu_op == 2'b10);
  wire is_branch = (alu_op == 2'b01) && alu_src_a;
  wire bad_op    = !(opcode inside {6'd0, 6'd2, 6'd4, 6'd35, 6'd43})
                || (opcode == 6'd0 && !funct_known);

  a_r3_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ir_write |=> is_decode);

  a_r4_exec_to_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exec && !alu_overflow) |=> (reg_write && reg_dst && !cause_write));

  a_r7_branch_follows_zero: assert property (@(posedge clk) disable iff (!rst_n)
    is_branch |-> (pc_load == alu_zero && pc_source == 2'b01));

  a_r9_undefined_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_decode && bad_op) |=> (cause_write && !cause_code && epc_write && pc_source == 2'b11));

  a_r10_overflow_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (is_exec && alu_overflow) |=> (cause_write && cause_code && !reg_write));

  a_r1_exception_returns_to_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    cause_write |=> ir_write);

  a_r11_no_write_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_write && (mem_read || reg_write)) && !(cause_write && (mem_write || reg_write)));
endmodule

bind mc_control mc_control_props i_props (.*);

// File: tb/test_mc_control.sv
module test_mc_control;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic clk = 0, rst_n = 0;
  logic [5:0] opcode = '0;
  logic funct_known = 0, alu_overflow = 0, alu_zero = 0;
  logic pc_load, iord, mem_read, mem_write, ir_write, mem_to_reg, reg_dst, reg_write;
  logic alu_src_a, cause_write, cause_code, epc_write;
  logic [1:0] alu_src_b, alu_op, pc_source;

  int checks = 0, fails = 0, cycles = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mc_control i_mc_control (.*);

  localparam int S_F = 0, S_D = 1, S_A = 2, S_MR = 3, S_LW = 4, S_MW = 5,
                 S_X = 6, S_RW = 7, S_B = 8, S_J = 9, S_U = 10, S_O = 11;

  // vector: pc_load iord mrd mwr irw m2r rdst rwr srca srcb[2] aluop[2] pcsrc[2] cw cc ew
  function automatic logic [17:0] pack(bit pl, bit io, bit mr, bit mw, bit iw, bit mtr,
      bit rd, bit rw, bit sa, bit [1:0] sb, bit [1:0] op, bit [1:0] ps, bit cw, bit cc, bit ew);
    return {pl, io, mr, mw, iw, mtr, rd, rw, sa, sb, op, ps, cw, cc, ew};
  endfunction

  function automatic logic [17:0] expect_ctrl(int s, bit z);
    case (s)
      S_F:  return pack(1,0,1,0,1,0,0,0,0,2'b01,2'b00,2'b00,0,0,0);
      S_D:  return pack(0,0,0,0,0,0,0,0,0,2'b11,2'b00,2'b00,0,0,0);
      S_A:  return pack(0,0,0,0,0,0,0,0,1,2'b10,2'b00,2'b00,0,0,0);
      S_MR: return pack(0,1,1,0,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0);
      S_LW: return pack(0,0,0,0,0,1,0,1,0,2'b00,2'b00,2'b00,0,0,0);
      S_MW: return pack(0,1,0,1,0,0,0,0,0,2'b00,2'b00,2'b00,0,0,0);
      S_X:  return pack(0,0,0,0,0,0,0,0,1,2'b00,2'b10,2'b00,0,0,0);
      S_RW: return pack(0,0,0,0,0,0,1,1,0,2'b00,2'b00,2'b00,0,0,0);
      S_B:  return pack(z,0,0,0,0,0,0,0,1,2'b00,2'b01,2'b01,0,0,0);
      S_J:  return pack(1,0,0,0,0,0,0,0,0,2'b00,2'b00,2'b10,0,0,0);
      S_U:  return pack(1,0,0,0,0,0,0,0,0,2'b01,2'b01,2'b11,1,0,1);
      default: return pack(1,0,0,0,0,0,0,0,0,2'b01,2'b01,2'b11,1,1,1);
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      S_F: return "R2"; S_D: return "R3"; S_X, S_RW: return "R4";
      S_A, S_MW: return "R5"; S_MR, S_LW: return "R6"; S_B: return "R7";
      S_J: return "R8"; S_U: return "R9"; default: return "R10";
    endcase
  endfunction

  function automatic bit undefined_instr(bit [5:0] op, bit fk);
    return !(op == 0 || op == 2 || op == 4 || op == 35 || op == 43) || (op == 0 && !fk);
  endfunction

  function automatic int next_state(int s, bit [5:0] op, bit fk, bit ov);
    case (s)
      S_F: return S_D;
      S_D: if (undefined_instr(op, fk)) return S_U;
           else if (op == 0) return S_X;
           else if (op == 4) return S_B;
           else if (op == 2) return S_J;
           else return S_A;
      S_A: return (op == 35) ? S_MR : S_MW;
      S_MR: return S_LW;
      S_X: return ov ? S_O : S_RW;
      default: return S_F;
    endcase
  endfunction

  function automatic int length_of(bit [5:0] op, bit fk);
    if (undefined_instr(op, fk)) return 3;
    if (op == 35) return 5;
    if (op == 4 || op == 2) return 3;
    return 4;
  endfunction

  function automatic logic [17:0] actual();
    return {pc_load, iord, mem_read, mem_write, ir_write, mem_to_reg, reg_dst, reg_write,
            alu_src_a, alu_src_b, alu_op, pc_source, cause_write, cause_code, epc_write};
  endfunction

  task automatic check_vec(string tag, logic [17:0] exp);
    checks++;
    if (actual() !== exp) begin
      fails++;
      $display("FAIL %s op=%0d: controls %b expected %b", tag, opcode, actual(), exp);
    end
  endtask

  task automatic run_instr(bit [5:0] op, bit fk, bit ov, bit z);
    int s = S_F, n = 0;
    opcode = op; funct_known = fk; alu_overflow = ov; alu_zero = z;
    do begin
      #1;
      check_vec(tag_of(s), expect_ctrl(s, z));
      @(posedge clk);
      s = next_state(s, op, fk, ov);
      n++;
      @(negedge clk);
    end while (s != S_F && n < 8);
    checks++;
    if (n != length_of(op, fk)) begin
      fails++;
      $display("FAIL %s op=%0d fk=%0d: cycles %0d expected %0d",
               undefined_instr(op, fk) ? "R9" : "R4-length", op, fk, n, length_of(op, fk));
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    #1 check_vec("R1", expect_ctrl(S_F, 0));
    @(negedge clk) rst_n = 1;
    for (int op = 0; op < 64; op++)
      for (int v = 0; v < 8; v++)
        run_instr(op[5:0], v[2], v[1], v[0]);
    // R1: reset in the middle of a load restarts at fetch
    opcode = 6'd35; funct_known = 1; alu_overflow = 0; alu_zero = 0;
    repeat (3) @(negedge clk);
    rst_n = 0;
    #1 check_vec("R1", expect_ctrl(S_F, 0));
    @(negedge clk) rst_n = 1;
    #1 check_vec("R1", expect_ctrl(S_F, 0));
    @(negedge clk);
    #1 check_vec("R1", expect_ctrl(S_D, 0));
    done = 1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: cycles %0d expected completion below %0d", cycles, WATCHDOG);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule